// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Unit

This block watches a small group of interrupt inputs and raises one sticky request flag per channel when a programmed edge appears. Each channel has a two-bit edge mode (off, rising, falling, either) and a two-bit source choice. The source choice selects either the channel's own pin or an alternate on-chip event line, for example a serial receive line, a serial clock, a suspend event or a timer tick. The selected line is brought into the system clock domain by a two-flop synchronizer. Edges are found by comparing each new synchronized sample with the one before it.

Software reaches the block through a register port that is one word wide. Writes take effect on the clock edge. Reads return data one cycle after the address is presented. A flag stays set until software writes a one to its bit. Priority arbitration and vector generation belong to the interrupt controller that consumes `irq_req`.

Top module: `exti_unit`

## Requirements
- R1: After reset, the mode register (address 0), the source register (address 1), the flag register (address 2) and `irq_req` all read as zero.
- R2: A channel whose mode field is 00 never sets its flag on any input change. Channel n's mode field is bits 2n+1:2n of address 0.
- R3: Mode 01 sets the flag on a rising edge of the selected input and ignores falling edges.
- R4: Mode 10 sets the flag on a falling edge of the selected input and ignores rising edges.
- R5: Mode 11 sets the flag on both rising and falling edges.
- R6: Source code 01 routes `alt_in[n]` to the detector. Changes on `pin_in[n]` then cause no request. Channel n's source field is bits 2n+1:2n of address 1.
- R7: Source code 00 routes `pin_in[n]` to the detector. Changes on `alt_in[n]` then cause no request.
- R8: A write of code 10 or 11 to a source field is stored as 00. It reads back as 00 and selects the pin.
- R9: A flag stays set until a write to address 2 has a 1 in bit n. Writing 0 to bit n leaves the flag unchanged.
- R10: When an edge is detected in the same cycle as a clear write for that channel, the flag stays set.
- R11: The flag and `irq_req[n]` rise on the third rising clock edge after the input changes. Read data appears on the clock edge that follows the address. Mode bits above 2*NCH and address 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (0 mode, 1 source, 2 flags) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| pin_in | input | NCH | Default asynchronous interrupt pins |
| alt_in | input | NCH | Alternate on-chip event sources |
| irq_req | output | NCH | Sticky per-channel request flags |

## Verification
A detected edge and a software clear can land on the same clock edge for the same flag. The bench provokes this by setting a flag with one rising edge and later raising the pin again. It times the clear write so that it is sampled on exactly the edge where the second detection takes effect, counted from the pin change through the synchronizer and the previous-sample register. The flag must still be set afterwards. The same clear issued with no edge pending must drop the flag, which shows that the clear itself works.

// File: rtl/exti_pkg.sv
package exti_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_t;

  localparam logic [1:0] SRC_PIN = 2'b00;
  localparam logic [1:0] SRC_ALT = 2'b01;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/exti_chan.sv
module exti_chan
  import exti_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic       alt_i,
  input  edge_mode_t mode_i,
  input  logic [1:0] src_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic sel_raw, smp, prev, rise, fall, hit, flag_q;

  assign sel_raw = (src_i == SRC_ALT) ? alt_i : pin_i;

  exti_sync #(.STAGES(SYNC_STAGES), .W(1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sel_raw),
    .q_o (smp)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= smp;
  end

  assign rise = smp & ~prev;
  assign fall = ~smp & prev;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= hit | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == EDGE_OFF && !flag_q) |=> !flag_q);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);

  // R10
  clr_lose_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (rise || fall) && mode_i == EDGE_ANY) |=> flag_q);
endmodule

// File: rtl/exti_unit.sv
module exti_unit
  import exti_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 16,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NCH-1:0] pin_in,
  input  logic [NCH-1:0] alt_in,
  output logic [NCH-1:0] irq_req
);
  localparam int FW = 2 * NCH;

  logic [FW-1:0]  mode_q, src_q, src_legal;
  logic [NCH-1:0] clr, flags;
  logic           wr_mode, wr_src, wr_flag;

  assign wr_mode = reg_we && (reg_addr == AW'(ADDR_MODE));
  assign wr_src  = reg_we && (reg_addr == AW'(ADDR_SRC));
  assign wr_flag = reg_we && (reg_addr == AW'(ADDR_FLAG));

  always_comb begin
    for (int n = 0; n < NCH; n++)
      src_legal[2*n +: 2] = (reg_wdata[2*n +: 2] == SRC_ALT) ? SRC_ALT : SRC_PIN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      src_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[FW-1:0];
      if (wr_src)  src_q  <= src_legal;
    end
  end

  assign clr = wr_flag ? reg_wdata[NCH-1:0] : '0;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      exti_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in[g]),
        .alt_i  (alt_in[g]),
        .mode_i (edge_mode_t'(mode_q[2*g +: 2])),
        .src_i  (src_q[2*g +: 2]),
        .clr_i  (clr[g]),
        .flag_o (flags[g])
      );

      // R8
      src_legal_chk: assert property (@(posedge clk) disable iff (rst)
        !src_q[2*g+1]);
    end
  endgenerate

  assign irq_req = flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        AW'(ADDR_MODE): reg_rdata[FW-1:0]  <= mode_q;
        AW'(ADDR_SRC):  reg_rdata[FW-1:0]  <= src_q;
        AW'(ADDR_FLAG): reg_rdata[NCH-1:0] <= flags;
        default:        reg_rdata <= '0;
      endcase
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && reg_rdata == '0));
endmodule

// File: tb/test_exti_unit.sv
module test_exti_unit;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int AW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] alt_in = '0;
  logic [NCH-1:0] irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exti_unit #(.NCH(NCH), .DW(DW), .AW(AW)) i_exti_unit (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .alt_in(alt_in), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", 32'(irq_req), 0);
    rd(0, v); check("R1 mode", 32'(v), 0);
    rd(1, v); check("R1 src", 32'(v), 0);
    rd(2, v); check("R1 flag", 32'(v), 0);

    // R11 unused bits and address 3
    wr(0, 16'hFFFF); rd(0, v); check("R11 mode width", 32'(v), 32'h00FF);
    rd(3, v); check("R11 addr3", 32'(v), 0);
    wr(0, 16'h0000);

    // R8 illegal source codes
    wr(1, 16'b11_10_01_00); rd(1, v); check("R8 legalize", 32'(v), 32'b00_00_01_00);
    wr(1, 16'h0000);

    // sweep: channel, mode, source code, direction, toggled input
    for (int ch = 0; ch < NCH; ch++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          for (int dir = 0; dir < 2; dir++)
            for (int tgt = 0; tgt < 2; tgt++) begin
              logic init;
              logic fire;
              init = (dir == 1);
              pin_in = {NCH{init}};
              alt_in = {NCH{init}};
              wr(0, DW'(m << (2*ch)));
              wr(1, DW'(s << (2*ch)));
              idle(5);
              wr(2, '1);
              idle(1);
              @(negedge clk);
              if (tgt == 0) pin_in[ch] = ~init; else alt_in[ch] = ~init;
              idle(4);
              fire = ((s == 1) == (tgt == 1)) &&
                     ((dir == 0 && m[0]) || (dir == 1 && m[1]));
              // R2 R3 R4 R5 R6 R7 R8
              check($sformatf("R2-mode R3 R4 R5 R6 R7 R8 ch%0d m%0d s%0d d%0d t%0d",
                              ch, m, s, dir, tgt),
                    32'(irq_req), fire ? (32'd1 << ch) : 32'd0);
              wr(2, '1);
            end

    // R9 sticky, write 0 no effect, write 1 clears
    pin_in = '0; alt_in = '0;
    wr(1, 16'h0000); wr(0, 16'h0001);
    idle(5); wr(2, '1); idle(1);
    pin_in[0] = 1'b1; idle(4);
    pin_in[0] = 1'b0; idle(4);
    check("R9 sticky", 32'(irq_req), 1);
    wr(2, 16'h000E); check("R9 zero write", 32'(irq_req), 1);
    rd(2, v); check("R9 readback", 32'(v), 1);
    wr(2, 16'h0001); check("R9 clear", 32'(irq_req), 0);

    // R11 exact latency
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); check("R11 lat1", 32'(irq_req[0]), 0);
    @(negedge clk); check("R11 lat2", 32'(irq_req[0]), 0);
    @(negedge clk); check("R11 lat3", 32'(irq_req[0]), 1);

    // R10 clear in the cycle a new edge lands
    pin_in[0] = 1'b0; idle(4);
    check("R10 pre", 32'(irq_req[0]), 1);
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0;
    check("R10 edge wins", 32'(irq_req[0]), 1);
    idle(2);
    wr(2, 16'h0001); check("R10 plain clear", 32'(irq_req[0]), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule